// File: doc/BRIEF.md
# Multi-Sector Flash Erase Sequencer

This block runs the erase of a flash array that is split into equal sectors. The default array has eight sectors of 64 KB, which gives a 19-bit byte address whose top three bits pick the sector. The host presents a sector-select mask and a one-cycle start request. The mask may name one sector or any combination of sectors. The sequencer then erases every selected sector without further host action. It visits the sectors in ascending index order and drives a per-sector erase enable toward the array model for a fixed number of cycles per sector.

A running erase can be suspended so that the read path can serve sectors that are not affected, and it can be resumed later. The interrupted sector keeps its remaining cycle count. While the erase is suspended, a permit vector and a per-address permit bit tell the read path which sectors are safe to read. Status outputs report busy and suspended, and a one-cycle done pulse marks the end of each operation.

Top module: `sector_erase_ctrl`

## Requirements
- R1: After reset, busy, suspended, done and every eraseEn bit are 0, and permitMask is all ones.
- R2: Selected sectors are erased in ascending index order and sectors whose mask bit is 0 are skipped. Bit i of sectorMask and bit i of eraseEn both refer to sector i, and eraseEn has at most one bit set.
- R3: Each selected sector has its eraseEn bit high for exactly ERASE_CYCLES (default 16) working cycles. Sectors follow one another with no gap, and the first eraseEn cycle comes the cycle after the start request is accepted.
- R4: busy is 1 from the cycle after an accepted start through the last erase cycle. done is a single-cycle pulse in the cycle after the last erase cycle, and busy is 0 in that cycle.
- R5: A start with an all-zero mask raises done in the next cycle, with no eraseEn activity and busy staying 0.
- R6: A suspendReq seen in an erase cycle lets that cycle count as work. From the next cycle, suspended is 1, busy is 1 and eraseEn is 0. After resumeReq the erase continues in the next cycle from the saved count. A suspend on the final cycle of the last sector is ignored and the operation completes.
- R7: permitMask is all ones when idle and all zeros while erasing. While suspended, its bits are 0 for the sector under erase and for sectors still pending, and 1 for all others. readOk equals permitMask[readSector], where readSector is the top three bits of the byte address.
- R8: startReq is ignored while busy or suspended.
- R9: resumeReq is ignored unless the sequencer is suspended, and suspendReq is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start an erase with sectorMask |
| sectorMask | input | 8 | Sectors to erase, bit i = sector i |
| suspendReq | input | 1 | Request to pause the running erase |
| resumeReq | input | 1 | Request to continue a paused erase |
| readSector | input | 3 | Sector field (top address bits) of the pending read |
| eraseEn | output | 8 | Per-sector erase enable toward the array |
| busy | output | 1 | Operation in progress (including suspended) |
| suspended | output | 1 | Erase paused |
| done | output | 1 | One-cycle completion pulse |
| permitMask | output | 8 | Sectors the read path may access |
| readOk | output | 1 | Permit bit for readSector |

## Verification
The erase enable follows one clock edge after the start is accepted, and done follows one edge after the final erase cycle. Suspended, busy and the permit vector change one edge after suspendReq or resumeReq, and readOk follows readSector combinationally. Inputs are driven on the falling edge. A scoreboard monitor samples one time unit after each rising edge and pops one expected sector index for every cycle in which eraseEn is active, and a marker for every done pulse. The direct checks of suspend, permit and ignored requests are sampled at the falling edge that follows the edge on which the request was taken.

// File: rtl/erase_pkg.sv
package erase_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_SUSP  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic start;
    logic tick;
    logic idle;
    logic susp;
  } dpCtl_t;
endpackage

// File: rtl/erase_dp.sv
module erase_dp
  import erase_pkg::*;
#(
  parameter int NUM_SECTORS  = 8,
  parameter int ERASE_CYCLES = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpCtl_t                         ctl,
  input  logic [NUM_SECTORS-1:0]         startMask,
  input  logic [$clog2(NUM_SECTORS)-1:0] readSector,
  output logic [NUM_SECTORS-1:0]         eraseEn,
  output logic [NUM_SECTORS-1:0]         permitMask,
  output logic                           readOk,
  output logic                           lastCycle,
  output logic                           pendEmpty
);
  localparam int IDX_W = $clog2(NUM_SECTORS);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ERASE_CYCLES);

  logic [NUM_SECTORS-1:0] pendMask;
  logic [IDX_W-1:0]       curIdx;
  logic [CNT_W-1:0]       remCnt;
  logic [IDX_W-1:0]       firstIdx;
  logic [IDX_W-1:0]       nextIdx;

  function automatic logic [IDX_W-1:0] lowestIdx(input logic [NUM_SECTORS-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SECTORS - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [NUM_SECTORS-1:0] oneHot(input logic [IDX_W-1:0] idx);
    logic [NUM_SECTORS-1:0] r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction

  assign firstIdx  = lowestIdx(startMask);
  assign nextIdx   = lowestIdx(pendMask);
  assign lastCycle = (remCnt == CNT_W'(1));
  assign pendEmpty = (pendMask == '0);
  assign eraseEn   = ctl.tick ? oneHot(curIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      curIdx   <= '0;
      remCnt   <= '0;
    end else if (ctl.start) begin
      curIdx   <= firstIdx;
      pendMask <= startMask & ~oneHot(firstIdx);
      remCnt   <= FULL_CNT;
    end else if (ctl.tick) begin
      if (lastCycle) begin
        if (!pendEmpty) begin
          curIdx   <= nextIdx;
          pendMask <= pendMask & ~oneHot(nextIdx);
          remCnt   <= FULL_CNT;
        end else begin
          remCnt <= '0;
        end
      end else begin
        remCnt <= remCnt - CNT_W'(1);
      end
    end
  end

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_permit
    assign permitMask[s] = ctl.idle |
                           (ctl.susp & ~pendMask[s] & (curIdx != IDX_W'(s)));
  end

  assign readOk = permitMask[readSector];

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.idle) |-> (remCnt != '0 && remCnt <= FULL_CNT));

  // R7
  susp_permit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.susp |-> !permitMask[curIdx]);
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import erase_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   anySel,
  input  logic   suspendReq,
  input  logic   resumeReq,
  input  logic   lastCycle,
  input  logic   pendEmpty,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   suspended,
  output logic   done
);
  seqState_t state, stateNext;
  logic      doneNext;

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    ctl.start = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (anySel) begin
            ctl.start = 1'b1;
            stateNext = ST_ERASE;
          end else begin
            doneNext = 1'b1;
          end
        end
      end
      ST_ERASE: begin
        if (lastCycle && pendEmpty) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end else if (suspendReq) begin
          stateNext = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (resumeReq) stateNext = ST_ERASE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign ctl.tick  = (state == ST_ERASE);
  assign ctl.idle  = (state == ST_IDLE);
  assign ctl.susp  = (state == ST_SUSP);
  assign busy      = (state != ST_IDLE);
  assign suspended = (state == ST_SUSP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R6
  suspend_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && suspendReq && !(lastCycle && pendEmpty)) |=> (state == ST_SUSP));

  // R8
  hold_susp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && !resumeReq) |=> (state == ST_SUSP));
endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
  import erase_pkg::*;
#(
  parameter int NUM_SECTORS  = 8,
  parameter int ERASE_CYCLES = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           startReq,
  input  logic [NUM_SECTORS-1:0]         sectorMask,
  input  logic                           suspendReq,
  input  logic                           resumeReq,
  input  logic [$clog2(NUM_SECTORS)-1:0] readSector,
  output logic [NUM_SECTORS-1:0]         eraseEn,
  output logic                           busy,
  output logic                           suspended,
  output logic                           done,
  output logic [NUM_SECTORS-1:0]         permitMask,
  output logic                           readOk
);
  dpCtl_t ctl;
  logic   lastCycle;
  logic   pendEmpty;

  erase_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .anySel    (|sectorMask),
    .suspendReq(suspendReq),
    .resumeReq (resumeReq),
    .lastCycle (lastCycle),
    .pendEmpty (pendEmpty),
    .ctl       (ctl),
    .busy      (busy),
    .suspended (suspended),
    .done      (done)
  );

  erase_dp #(
    .NUM_SECTORS (NUM_SECTORS),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .startMask (sectorMask),
    .readSector(readSector),
    .eraseEn   (eraseEn),
    .permitMask(permitMask),
    .readOk    (readOk),
    .lastCycle (lastCycle),
    .pendEmpty (pendEmpty)
  );

  // R2
  onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(eraseEn));

  // R6
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> (eraseEn == '0 && busy));
endmodule

// File: tb/sector_erase_ctrl_test.sv
module sector_erase_ctrl_test;
  localparam int NS = 8;
  localparam int EC = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [NS-1:0] sectorMask = '0;
  logic          suspendReq = 1'b0;
  logic          resumeReq = 1'b0;
  logic [2:0]    readSector = '0;
  logic [NS-1:0] eraseEn;
  logic          busy, suspended, done, readOk;
  logic [NS-1:0] permitMask;

  int expQ[$];
  int nCmp = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  sector_erase_ctrl #(.NUM_SECTORS(NS), .ERASE_CYCLES(EC)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sectorMask(sectorMask),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .readSector(readSector),
    .eraseEn(eraseEn), .busy(busy), .suspended(suspended), .done(done),
    .permitMask(permitMask), .readOk(readOk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard driver side: one entry per expected erase cycle, -1 for done
  task automatic queueOp(input logic [NS-1:0] m);
    for (int i = 0; i < NS; i++)
      if (m[i]) for (int k = 0; k < EC; k++) expQ.push_back(i);
    expQ.push_back(-1);
  endtask

  task automatic startOp(input logic [NS-1:0] m);
    @(negedge clk);
    sectorMask = m;
    startReq   = 1'b1;
    @(negedge clk);
    startReq   = 1'b0;
  endtask

  task automatic drain();
    for (int g = 0; g < 400 && expQ.size() != 0; g++) @(negedge clk);
    chk(expQ.size() == 0, "R3", "scoreboard drained", expQ.size(), 0);
    @(negedge clk);
  endtask

  // Scoreboard monitor side
  always @(posedge clk) begin
    int e;
    #1;
    if (rstN) begin
      if (eraseEn != '0) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected eraseEn", int'(eraseEn), 0);
        end else begin
          e = expQ.pop_front();
          if (e < 0) chk(1'b0, "R3", "eraseEn where done expected", int'(eraseEn), 0);
          else chk(eraseEn == (NS'(1) << e), "R2", "eraseEn sector order", int'(eraseEn), 1 << e);
        end
      end
      if (done) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4", "unexpected done", 1, 0);
        end else begin
          e = expQ.pop_front();
          chk(e == -1, "R4", "done before all erase cycles", -1, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && suspended == 0 && done == 0, "R1", "status after reset",
        {busy, suspended, done}, 0);
    chk(eraseEn == '0, "R1", "eraseEn after reset", int'(eraseEn), 0);
    chk(permitMask == '1, "R1", "permitMask after reset", int'(permitMask), 255);

    // R9 suspend while idle is ignored
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    @(negedge clk);
    chk(suspended == 0 && busy == 0, "R9", "suspend while idle", {busy, suspended}, 0);

    // R2 R3 R4 R7 multi-sector erase
    queueOp(8'b1010_0101);
    startOp(8'b1010_0101);
    chk(busy == 1, "R4", "busy after start", busy, 1);
    chk(eraseEn == 8'h01, "R3", "first eraseEn cycle", int'(eraseEn), 1);
    chk(permitMask == '0, "R7", "permit while erasing", int'(permitMask), 0);
    readSector = 3'd4;
    #1;
    chk(readOk == 0, "R7", "readOk while erasing", readOk, 0);
    drain();

    // R5 zero mask
    queueOp('0);
    startOp('0);
    chk(done == 1 && busy == 0 && eraseEn == '0, "R5", "zero mask completion",
        {done, busy, |eraseEn}, 4);
    @(negedge clk);
    chk(done == 0, "R5", "done single cycle", done, 0);

    // R6 R7 R8 suspend and resume
    queueOp(8'b0001_1010);
    startOp(8'b0001_1010);
    repeat (4) @(negedge clk);
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    chk(suspended == 1 && busy == 1, "R6", "suspended status", {busy, suspended}, 3);
    chk(eraseEn == '0, "R6", "no erase while suspended", int'(eraseEn), 0);
    chk(permitMask == 8'hE5, "R7", "permit while suspended", int'(permitMask), 229);
    readSector = 3'd2;
    #1;
    chk(readOk == 1, "R7", "readOk unaffected sector", readOk, 1);
    readSector = 3'd3;
    #1;
    chk(readOk == 0, "R7", "readOk pending sector", readOk, 0);
    readSector = 3'd1;
    #1;
    chk(readOk == 0, "R7", "readOk sector under erase", readOk, 0);
    sectorMask = 8'hFF;
    startReq   = 1'b1;
    @(negedge clk);
    startReq   = 1'b0;
    @(negedge clk);
    chk(suspended == 1 && permitMask == 8'hE5, "R8", "start while suspended",
        int'(permitMask), 229);
    repeat (3) @(negedge clk);
    chk(eraseEn == '0, "R6", "still quiet while suspended", int'(eraseEn), 0);
    resumeReq = 1'b1;
    @(negedge clk);
    resumeReq = 1'b0;
    chk(suspended == 0 && eraseEn == 8'h02, "R6", "resume continues sector 1",
        int'(eraseEn), 2);
    drain();

    // R8 R9 start and resume while erasing are ignored
    queueOp(8'h80);
    startOp(8'h80);
    sectorMask = 8'h01;
    startReq   = 1'b1;
    resumeReq  = 1'b1;
    @(negedge clk);
    startReq   = 1'b0;
    resumeReq  = 1'b0;
    chk(suspended == 0 && busy == 1, "R9", "resume while erasing", {busy, suspended}, 2);
    chk(eraseEn == 8'h80, "R8", "start while busy", int'(eraseEn), 128);
    drain();

    // R6 suspend on final cycle of last sector completes
    queueOp(8'h40);
    startOp(8'h40);
    repeat (15) @(negedge clk);
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    chk(done == 1 && busy == 0 && suspended == 0, "R6", "suspend on last cycle ignored",
        {done, busy, suspended}, 4);
    @(negedge clk);
    chk(done == 0, "R4", "done one cycle", done, 0);
    chk(permitMask == '1, "R7", "permit idle after op", int'(permitMask), 255);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule